// File: doc/BRIEF.md
# Configurable GPIO Port Controller

This block runs one 8-pin general-purpose I/O port behind a small synchronous register bus. Every pin has its own bit in seven configuration registers: output data, direction, reduced drive, pull enable, pull select, open-drain (wired-or) mode and interrupt enable. From these bits the block computes the pad controls for each pin: output value, output enable, pull-up enable, pull-down enable and the reduced-drive control.

An on-chip peripheral can take over any pin through a per-pin override input. Its data and enable then replace the port's own data and direction bits. Pin levels pass through a two-flop synchronizer. A pin-change detector sets a sticky interrupt flag on the edge that the pull-select bit chooses. Software clears a flag by writing 1 to it. The flags are masked per pin and ORed into a single interrupt request.

Top module: `gpio_port_ctrl`

## Requirements
- R1: After reset every register reads 0, so all pins are inputs with pulls off, full drive, push-pull mode and interrupts masked. At the pads, `padOe`, `padPullUp`, `padPullDn`, `padReducedDrive` and `irqReq` are all 0.
- R2: A write is stored at the clock edge where `busWrEn` is high. `busRdData` shows the register addressed in the previous cycle. The register map is: 0 data, 1 pin input (read only), 2 direction (1 = output), 3 reduced drive, 4 pull enable, 5 pull select, 6 wired-or mode, 7 interrupt enable, 8 interrupt flags. Any other address reads 0.
- R3: A push-pull output pin has `padOe` = 1 and `padOut` equal to its data bit. An input pin has `padOe` = 0.
- R4: In wired-or mode `padOut` is 0. An output pin whose data bit is 1 gets `padOe` = 0 so that it floats. An output pin whose data bit is 0 gets `padOe` = 1 so that it drives low.
- R5: A pull device is on only when its enable bit is 1 and the pin is either an input or a wired-or output. In every other case both pull controls are 0.
- R6: On an input pin, a pull-select bit of 1 chooses the pull-down and 0 chooses the pull-up. A wired-or output only ever gets the pull-up, whatever the select bit holds.
- R7: `padReducedDrive` follows the reduced-drive bit only while the pin is an output. On an input pin it is 0.
- R8: While `modEn` is 1 for a pin, `modDataOut` and `modOutEn` take the place of that pin's data bit and direction bit in the pad logic.
- R9: Pin levels reach the registers through two synchronizer flops. Reading the data register returns the synchronized level for input pins and the stored bit for output pins. The pin input register always returns the synchronized level.
- R10: A flag is set on a rising synchronized edge when the pin's pull-select bit is 1, and on a falling edge when it is 0.
- R11: Writing 1 to a flag bit clears it, and writing 0 leaves it unchanged. If an edge is detected in the same cycle as the clear, the flag stays set.
- R12: `irqReq` is 1 exactly when at least one flag and its interrupt-enable bit are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| busAddr | input | 4 | Register address |
| busWrData | input | 8 | Write data |
| busWrEn | input | 1 | Write strobe |
| busRdData | output | 8 | Registered read data |
| pinIn | input | 8 | Pad input levels (asynchronous) |
| modEn | input | 8 | Per-pin peripheral override enable |
| modDataOut | input | 8 | Peripheral output data |
| modOutEn | input | 8 | Peripheral output enable |
| padOut | output | 8 | Pad output value |
| padOe | output | 8 | Pad output enable |
| padPullUp | output | 8 | Pull-up enable |
| padPullDn | output | 8 | Pull-down enable |
| padReducedDrive | output | 8 | Reduced drive-strength control |
| irqReq | output | 1 | Combined interrupt request |

## Verification
The bench builds the block with its defaults: eight pins and two synchronizer stages. With these values all 256 combinations of one byte are available, so a single configuration can place push-pull, wired-or, input and overridden pins side by side and every pad rule is visible in one cycle. The two-stage latency makes it possible to time a pin edge so that its detection lands on the same clock edge as a flag-clear write, which is the collision case of R11.

// File: rtl/gpio_port_pkg.sv
package gpio_port_pkg;

  localparam int REG_ADDR_W = 4;

  typedef enum logic [REG_ADDR_W-1:0] {
    RS_DATA    = 4'd0,
    RS_INPUT   = 4'd1,
    RS_DIR     = 4'd2,
    RS_RDRV    = 4'd3,
    RS_PULLEN  = 4'd4,
    RS_PULLSEL = 4'd5,
    RS_WOR     = 4'd6,
    RS_IRQEN   = 4'd7,
    RS_FLAG    = 4'd8
  } regSel_e;

  // strobes from bus control to the datapath
  typedef struct packed {
    logic    wrData;
    logic    wrDir;
    logic    wrRdrv;
    logic    wrPullEn;
    logic    wrPullSel;
    logic    wrWor;
    logic    wrIrqEn;
    logic    clrFlag;
    regSel_e rdSel;
  } portStrobe_t;

endpackage

// File: rtl/gpio_bus_ctrl.sv
module gpio_bus_ctrl
  import gpio_port_pkg::*;
(
  input  logic [REG_ADDR_W-1:0] busAddr,
  input  logic                  busWrEn,
  output portStrobe_t           strobe
);

  always_comb begin
    strobe       = '0;
    strobe.rdSel = regSel_e'(busAddr);
    if (busWrEn) begin
      case (busAddr)
        RS_DATA:    strobe.wrData    = 1'b1;
        RS_DIR:     strobe.wrDir     = 1'b1;
        RS_RDRV:    strobe.wrRdrv    = 1'b1;
        RS_PULLEN:  strobe.wrPullEn  = 1'b1;
        RS_PULLSEL: strobe.wrPullSel = 1'b1;
        RS_WOR:     strobe.wrWor     = 1'b1;
        RS_IRQEN:   strobe.wrIrqEn   = 1'b1;
        RS_FLAG:    strobe.clrFlag   = 1'b1;
        default:    ;
      endcase
    end
  end

endmodule

// File: rtl/gpio_pad_cell.sv
module gpio_pad_cell (
  input  logic dataBit,
  input  logic dirBit,
  input  logic rdrvBit,
  input  logic pullEnBit,
  input  logic pullSelBit,
  input  logic worBit,
  input  logic modEnBit,
  input  logic modDataBit,
  input  logic modOeBit,
  output logic padOutBit,
  output logic padOeBit,
  output logic pullUpBit,
  output logic pullDnBit,
  output logic reducedBit
);

  logic effData;
  logic effDir;
  logic pullOn;

  // peripheral override replaces data and direction
  assign effData = modEnBit ? modDataBit : dataBit;
  assign effDir  = modEnBit ? modOeBit   : dirBit;

  // open-drain: never drive high, release instead
  assign padOutBit = effData & ~worBit;
  assign padOeBit  = effDir & ~(worBit & effData);

  // pulls only for inputs or open-drain outputs; outputs get pull-up only
  assign pullOn    = pullEnBit & (~effDir | worBit);
  assign pullUpBit = pullOn & (effDir | ~pullSelBit);
  assign pullDnBit = pullOn & ~effDir & pullSelBit;

  assign reducedBit = effDir & rdrvBit;

endmodule

// File: rtl/gpio_port_dp.sv
module gpio_port_dp
  import gpio_port_pkg::*;
#(
  parameter int NUM_PINS    = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                clk,
  input  logic                rstN,
  input  portStrobe_t         strobe,
  input  logic [NUM_PINS-1:0] wrData,
  input  logic [NUM_PINS-1:0] pinIn,
  input  logic [NUM_PINS-1:0] modEn,
  input  logic [NUM_PINS-1:0] modDataOut,
  input  logic [NUM_PINS-1:0] modOutEn,
  output logic [NUM_PINS-1:0] rdData,
  output logic [NUM_PINS-1:0] padOut,
  output logic [NUM_PINS-1:0] padOe,
  output logic [NUM_PINS-1:0] padPullUp,
  output logic [NUM_PINS-1:0] padPullDn,
  output logic [NUM_PINS-1:0] padReducedDrive,
  output logic                irqReq,
  output logic [NUM_PINS-1:0] worQ,
  output logic [NUM_PINS-1:0] pullEnQ,
  output logic [NUM_PINS-1:0] rdrvQ,
  output logic [NUM_PINS-1:0] irqEnQ,
  output logic [NUM_PINS-1:0] flagQ
);

  localparam int LAST_STAGE = SYNC_STAGES - 1;

  logic [NUM_PINS-1:0] dataQ, dirQ, pullSelQ;
  logic [NUM_PINS-1:0] syncPipe [SYNC_STAGES];
  logic [NUM_PINS-1:0] syncLvl, prevLvl;
  logic [NUM_PINS-1:0] riseV, fallV, edgeV, clrMask;
  logic [NUM_PINS-1:0] rdNext;

  // configuration registers
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataQ    <= '0;
      dirQ     <= '0;
      rdrvQ    <= '0;
      pullEnQ  <= '0;
      pullSelQ <= '0;
      worQ     <= '0;
      irqEnQ   <= '0;
    end else begin
      if (strobe.wrData)    dataQ    <= wrData;
      if (strobe.wrDir)     dirQ     <= wrData;
      if (strobe.wrRdrv)    rdrvQ    <= wrData;
      if (strobe.wrPullEn)  pullEnQ  <= wrData;
      if (strobe.wrPullSel) pullSelQ <= wrData;
      if (strobe.wrWor)     worQ     <= wrData;
      if (strobe.wrIrqEn)   irqEnQ   <= wrData;
    end
  end

  // input synchronizer and edge history
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int s = 0; s < SYNC_STAGES; s++) syncPipe[s] <= '0;
      prevLvl <= '0;
    end else begin
      syncPipe[0] <= pinIn;
      for (int s = 1; s < SYNC_STAGES; s++) syncPipe[s] <= syncPipe[s-1];
      prevLvl <= syncLvl;
    end
  end

  assign syncLvl = syncPipe[LAST_STAGE];
  assign riseV   = syncLvl & ~prevLvl;
  assign fallV   = ~syncLvl & prevLvl;
  assign edgeV   = (pullSelQ & riseV) | (~pullSelQ & fallV);
  assign clrMask = strobe.clrFlag ? wrData : '0;

  // sticky flags, set wins over clear
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) flagQ <= '0;
    else       flagQ <= (flagQ & ~clrMask) | edgeV;
  end

  assign irqReq = |(flagQ & irqEnQ);

  // read mux, registered
  always_comb begin
    case (strobe.rdSel)
      RS_DATA:    rdNext = (dirQ & dataQ) | (~dirQ & syncLvl);
      RS_INPUT:   rdNext = syncLvl;
      RS_DIR:     rdNext = dirQ;
      RS_RDRV:    rdNext = rdrvQ;
      RS_PULLEN:  rdNext = pullEnQ;
      RS_PULLSEL: rdNext = pullSelQ;
      RS_WOR:     rdNext = worQ;
      RS_IRQEN:   rdNext = irqEnQ;
      RS_FLAG:    rdNext = flagQ;
      default:    rdNext = '0;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rdData <= '0;
    else       rdData <= rdNext;
  end

  // per-pin pad control
  for (genvar p = 0; p < NUM_PINS; p++) begin : gPad
    gpio_pad_cell padCell_i (
      .dataBit    (dataQ[p]),
      .dirBit     (dirQ[p]),
      .rdrvBit    (rdrvQ[p]),
      .pullEnBit  (pullEnQ[p]),
      .pullSelBit (pullSelQ[p]),
      .worBit     (worQ[p]),
      .modEnBit   (modEn[p]),
      .modDataBit (modDataOut[p]),
      .modOeBit   (modOutEn[p]),
      .padOutBit  (padOut[p]),
      .padOeBit   (padOe[p]),
      .pullUpBit  (padPullUp[p]),
      .pullDnBit  (padPullDn[p]),
      .reducedBit (padReducedDrive[p])
    );
  end

endmodule

// File: rtl/gpio_port_ctrl.sv
module gpio_port_ctrl
  import gpio_port_pkg::*;
#(
  parameter int NUM_PINS    = 8,
  parameter int SYNC_STAGES = 2
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [REG_ADDR_W-1:0] busAddr,
  input  logic [NUM_PINS-1:0]   busWrData,
  input  logic                  busWrEn,
  output logic [NUM_PINS-1:0]   busRdData,
  input  logic [NUM_PINS-1:0]   pinIn,
  input  logic [NUM_PINS-1:0]   modEn,
  input  logic [NUM_PINS-1:0]   modDataOut,
  input  logic [NUM_PINS-1:0]   modOutEn,
  output logic [NUM_PINS-1:0]   padOut,
  output logic [NUM_PINS-1:0]   padOe,
  output logic [NUM_PINS-1:0]   padPullUp,
  output logic [NUM_PINS-1:0]   padPullDn,
  output logic [NUM_PINS-1:0]   padReducedDrive,
  output logic                  irqReq
);

  portStrobe_t         strobe;
  logic [NUM_PINS-1:0] worQ, pullEnQ, rdrvQ, irqEnQ, flagQ;

  gpio_bus_ctrl busCtrl_i (
    .busAddr (busAddr),
    .busWrEn (busWrEn),
    .strobe  (strobe)
  );

  gpio_port_dp #(
    .NUM_PINS    (NUM_PINS),
    .SYNC_STAGES (SYNC_STAGES)
  ) portDp_i (
    .clk             (clk),
    .rstN            (rstN),
    .strobe          (strobe),
    .wrData          (busWrData),
    .pinIn           (pinIn),
    .modEn           (modEn),
    .modDataOut      (modDataOut),
    .modOutEn        (modOutEn),
    .rdData          (busRdData),
    .padOut          (padOut),
    .padOe           (padOe),
    .padPullUp       (padPullUp),
    .padPullDn       (padPullDn),
    .padReducedDrive (padReducedDrive),
    .irqReq          (irqReq),
    .worQ            (worQ),
    .pullEnQ         (pullEnQ),
    .rdrvQ           (rdrvQ),
    .irqEnQ          (irqEnQ),
    .flagQ           (flagQ)
  );

endmodule

// File: rtl/gpio_port_ctrl_chk.sv
module gpio_port_ctrl_chk
  import gpio_port_pkg::*;
#(
  parameter int NUM_PINS = 8
) (
  input logic                  clk,
  input logic                  rstN,
  input logic [REG_ADDR_W-1:0] busAddr,
  input logic [NUM_PINS-1:0]   busWrData,
  input logic                  busWrEn,
  input logic [NUM_PINS-1:0]   padOut,
  input logic [NUM_PINS-1:0]   padOe,
  input logic [NUM_PINS-1:0]   padPullUp,
  input logic [NUM_PINS-1:0]   padPullDn,
  input logic [NUM_PINS-1:0]   padReducedDrive,
  input logic                  irqReq,
  input logic [NUM_PINS-1:0]   worReg,
  input logic [NUM_PINS-1:0]   pullEnReg,
  input logic [NUM_PINS-1:0]   rdrvReg,
  input logic [NUM_PINS-1:0]   irqEnReg,
  input logic [NUM_PINS-1:0]   flagReg
);

  logic [NUM_PINS-1:0] clearMask;
  assign clearMask = (busWrEn && busAddr == RS_FLAG) ? busWrData : '0;

  assert_wor_no_high_R4: assert property (@(posedge clk) disable iff (!rstN)
    (padOe & padOut & worReg) == '0);

  assert_pull_gate_R5: assert property (@(posedge clk) disable iff (!rstN)
    ((padPullUp | padPullDn) & ~pullEnReg) == '0);

  assert_pull_exclusive_R6: assert property (@(posedge clk) disable iff (!rstN)
    (padPullUp & padPullDn) == '0);

  assert_drive_gate_R7: assert property (@(posedge clk) disable iff (!rstN)
    (padReducedDrive & ~rdrvReg) == '0);

  assert_flag_sticky_R11: assert property (@(posedge clk) disable iff (!rstN)
    1'b1 |=> ((($past(flagReg) & ~flagReg) & ~$past(clearMask)) == '0));

  assert_irq_masked_R12: assert property (@(posedge clk) disable iff (!rstN)
    (irqEnReg == '0) |-> !irqReq);

endmodule

bind gpio_port_ctrl gpio_port_ctrl_chk #(.NUM_PINS(NUM_PINS)) chk_i (
  .clk             (clk),
  .rstN            (rstN),
  .busAddr         (busAddr),
  .busWrData       (busWrData),
  .busWrEn         (busWrEn),
  .padOut          (padOut),
  .padOe           (padOe),
  .padPullUp       (padPullUp),
  .padPullDn       (padPullDn),
  .padReducedDrive (padReducedDrive),
  .irqReq          (irqReq),
  .worReg          (worQ),
  .pullEnReg       (pullEnQ),
  .rdrvReg         (rdrvQ),
  .irqEnReg        (irqEnQ),
  .flagReg         (flagQ)
);

// File: tb/gpio_port_ctrl_tb_top.sv
module gpio_port_ctrl_tb_top;
  import gpio_port_pkg::*;

  localparam int NP = 8;

  logic          clk = 1'b0;
  logic          rstN;
  logic [3:0]    busAddr;
  logic [NP-1:0] busWrData;
  logic          busWrEn;
  logic [NP-1:0] busRdData;
  logic [NP-1:0] pinIn, modEn, modDataOut, modOutEn;
  logic [NP-1:0] padOut, padOe, padPullUp, padPullDn, padReducedDrive;
  logic          irqReq;

  int checks = 0;
  int fails  = 0;

  always #4 clk = ~clk;

  gpio_port_ctrl dut_i (
    .clk(clk), .rstN(rstN), .busAddr(busAddr), .busWrData(busWrData),
    .busWrEn(busWrEn), .busRdData(busRdData), .pinIn(pinIn), .modEn(modEn),
    .modDataOut(modDataOut), .modOutEn(modOutEn), .padOut(padOut),
    .padOe(padOe), .padPullUp(padPullUp), .padPullDn(padPullDn),
    .padReducedDrive(padReducedDrive), .irqReq(irqReq)
  );

  // ---------------- reference model ----------------
  logic [NP-1:0] mData, mDir, mRdrv, mPullEn, mPullSel, mWor, mIrqEn, mFlag, mRd;
  logic [NP-1:0] mHist[$];   // [0] newest sample, [1] synchronized, [2] previous
  logic [NP-1:0] tSync, tPrev, tEdge, tClr;

  function automatic logic [NP-1:0] modelRead(input logic [3:0] a, input logic [NP-1:0] lvl);
    logic [NP-1:0] r;
    case (a)
      4'd0: begin
        for (int b = 0; b < NP; b++) r[b] = mDir[b] ? mData[b] : lvl[b];
      end
      4'd1: r = lvl;
      4'd2: r = mDir;
      4'd3: r = mRdrv;
      4'd4: r = mPullEn;
      4'd5: r = mPullSel;
      4'd6: r = mWor;
      4'd7: r = mIrqEn;
      4'd8: r = mFlag;
      default: r = '0;
    endcase
    return r;
  endfunction

  always @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      mData = '0; mDir = '0; mRdrv = '0; mPullEn = '0; mPullSel = '0;
      mWor = '0; mIrqEn = '0; mFlag = '0; mRd = '0;
      mHist = '{'0, '0, '0};
    end else begin
      tSync = mHist[1];
      tPrev = mHist[2];
      for (int b = 0; b < NP; b++) begin
        if (mPullSel[b]) tEdge[b] = tSync[b] && !tPrev[b];
        else             tEdge[b] = !tSync[b] && tPrev[b];
      end
      mRd  = modelRead(busAddr, tSync);
      tClr = (busWrEn && busAddr == 4'd8) ? busWrData : '0;
      mFlag = (mFlag & ~tClr) | tEdge;
      if (busWrEn) begin
        case (busAddr)
          4'd0: mData    = busWrData;
          4'd2: mDir     = busWrData;
          4'd3: mRdrv    = busWrData;
          4'd4: mPullEn  = busWrData;
          4'd5: mPullSel = busWrData;
          4'd6: mWor     = busWrData;
          4'd7: mIrqEn   = busWrData;
          default: ;
        endcase
      end
      mHist.push_front(pinIn);
      void'(mHist.pop_back());
    end
  end

  task automatic chk(input string tag, input logic [NP-1:0] act, input logic [NP-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual %h expected %h at %0t", tag, act, exp, $time);
    end
  endtask

  // compare pads, read data and request every cycle
  always @(negedge clk) begin
    if (rstN === 1'b1) begin
      logic [NP-1:0] eOut, eOe, eUp, eDn, eRd;
      for (int b = 0; b < NP; b++) begin
        logic d, o, pullOn;
        d = modEn[b] ? modDataOut[b] : mData[b];
        o = modEn[b] ? modOutEn[b]   : mDir[b];
        eOut[b] = mWor[b] ? 1'b0 : d;
        if (!o)          eOe[b] = 1'b0;
        else if (mWor[b]) eOe[b] = !d;
        else             eOe[b] = 1'b1;
        pullOn = mPullEn[b] && (!o || mWor[b]);
        eUp[b] = pullOn && (o || !mPullSel[b]);
        eDn[b] = pullOn && !o && mPullSel[b];
        eRd[b] = o && mRdrv[b];
      end
      chk("R3 R4 R8 padOut", padOut, eOut);
      chk("R3 R4 R8 padOe", padOe, eOe);
      chk("R5 R6 padPullUp", padPullUp, eUp);
      chk("R5 R6 padPullDn", padPullDn, eDn);
      chk("R7 padReducedDrive", padReducedDrive, eRd);
      chk("R2 R9 busRdData", busRdData, mRd);
      chk("R10 R11 R12 irqReq", {7'd0, irqReq}, {7'd0, |(mFlag & mIrqEn)});
    end
  end

  // ---------------- bus tasks ----------------
  task automatic busWrite(input logic [3:0] a, input logic [NP-1:0] d);
    busAddr = a; busWrData = d; busWrEn = 1'b1;
    @(posedge clk); @(negedge clk);
    busWrEn = 1'b0;
  endtask

  task automatic busRead(input logic [3:0] a, output logic [NP-1:0] d);
    busAddr = a; busWrEn = 1'b0;
    @(posedge clk); @(negedge clk);
    d = busRdData;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic finishRun();
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired");
    finishRun();
  end

  initial begin
    logic [NP-1:0] rv;
    rstN = 1'b0; busAddr = '0; busWrData = '0; busWrEn = 1'b0;
    pinIn = '0; modEn = '0; modDataOut = '0; modOutEn = '0;
    idle(3);
    // R1 reset state at the pads
    chk("R1 padOe", padOe, '0);
    chk("R1 padPullUp", padPullUp, '0);
    chk("R1 padPullDn", padPullDn, '0);
    chk("R1 padReducedDrive", padReducedDrive, '0);
    chk("R1 irqReq", {7'd0, irqReq}, '0);
    chk("R1 busRdData", busRdData, '0);
    rstN = 1'b1;
    idle(1);
    busRead(4'd2, rv); chk("R1 direction after reset", rv, '0);
    busRead(4'd6, rv); chk("R1 wired-or after reset", rv, '0);

    // R2 configuration write and readback
    pinIn = 8'h5A;
    busWrite(4'd0, 8'hA5);
    busWrite(4'd2, 8'hF0);
    busWrite(4'd3, 8'h3C);
    busWrite(4'd4, 8'hFF);
    busWrite(4'd5, 8'hCF);
    busWrite(4'd6, 8'hC0);
    busRead(4'd3, rv); chk("R2 reduced drive readback", rv, 8'h3C);
    busRead(4'd5, rv); chk("R2 pull select readback", rv, 8'hCF);
    busRead(4'd6, rv); chk("R2 wired-or readback", rv, 8'hC0);
    busRead(4'd9, rv); chk("R2 unmapped address", rv, 8'h00);

    // pad rules with mixed pins
    chk("R3 R4 padOe mixed", padOe, 8'h70);
    chk("R4 padOut mixed", padOut, 8'h25);
    chk("R6 pull-up wired-or ignores select", padPullUp, 8'hC0);
    chk("R5 pull-down inputs only", padPullDn, 8'h0F);
    chk("R7 reduced drive outputs only", padReducedDrive, 8'h30);

    // R9 synchronized input reads
    busRead(4'd0, rv); chk("R9 data register mix", rv, 8'hAA);
    busRead(4'd1, rv); chk("R9 input register", rv, 8'h5A);

    // R8 peripheral override
    modEn = 8'h11; modDataOut = 8'h10; modOutEn = 8'h01;
    idle(1);
    chk("R8 override padOe", padOe, 8'h61);
    chk("R8 override padOut", padOut, 8'h34);
    modEn = '0; modDataOut = '0; modOutEn = '0;

    // interrupt setup: all inputs, push-pull
    busWrite(4'd2, 8'h00);
    busWrite(4'd6, 8'h00);
    busWrite(4'd5, 8'h0F);
    busWrite(4'd8, 8'hFF);
    busRead(4'd8, rv); chk("R11 flags cleared", rv, 8'h00);
    busWrite(4'd7, 8'hFF);
    pinIn = 8'hA5;
    idle(4);
    busRead(4'd8, rv); chk("R10 flags by edge direction", rv, 8'h55);
    chk("R12 request raised", {7'd0, irqReq}, 8'h01);
    busWrite(4'd7, 8'h0A); idle(1);
    chk("R12 request masked", {7'd0, irqReq}, 8'h00);
    busWrite(4'd7, 8'h04); idle(1);
    chk("R12 request single pin", {7'd0, irqReq}, 8'h01);
    busWrite(4'd8, 8'h05);
    busRead(4'd8, rv); chk("R11 write one clears", rv, 8'h50);

    // R11 edge detected in the same cycle as the clear
    pinIn[0] = 1'b0; idle(4);
    pinIn[0] = 1'b1; idle(4);
    pinIn[0] = 1'b0; idle(4);
    busRead(4'd8, rv); chk("R11 bit0 set before collision", rv, 8'h51);
    pinIn[0] = 1'b1;
    @(posedge clk); @(posedge clk); @(negedge clk);
    busWrite(4'd8, 8'h01);
    busRead(4'd8, rv); chk("R11 set wins over clear", rv, 8'h51);

    idle(2);
    finishRun();
  end

endmodule